// File: doc/BRIEF.md
# GPIO Register Bank with Input Polarity Inversion

This block keeps the four byte-wide port registers of a general-purpose I/O expander: a captured input register, an output value register, a polarity-inversion register and a direction register. A bus slave in front of it supplies a one-cycle write strobe with a register index and a data byte, and a one-cycle read strobe at the acknowledge phase of each byte it sends back. On the read strobe the pin levels, each XORed with its polarity bit, are latched into the input register. The selected register is always visible on the read data output.

The block drives an enable and a value for each of the eight pad drivers. Each bit is a push-pull pin, except bit 0, which is open-drain: it can pull low but never drives high. All registers return to fixed defaults on a synchronous active-low reset, so every pin comes up as an input.

Top module: `gpio_polreg_bank`

## Requirements
- R1: After reset the output register reads 0x00, the polarity register reads 0xF0, the direction register reads 0xFF, the input register reads 0x00 and no pad driver is enabled.
- R2: A write strobe with index 1 (output), 2 (polarity) or 3 (direction) stores the data byte in that register from the next cycle. Read index 1 returns the stored output byte, not the level seen on the pins.
- R3: A write strobe with index 0 (input register) changes no register.
- R4: A direction bit of 1 keeps that pin's driver disabled, whatever its output bit holds.
- R5: On a push-pull pin (bits 1 to 7) a direction bit of 0 enables the driver, and the driven value equals the stored output bit.
- R6: Bit 0 never drives high. Its driver is enabled only when its direction bit is 0 and its output bit is 0, and its driven value is always 0.
- R7: A read strobe stores pin_in XOR polarity into the input register, which read index 0 returns from the next cycle. With no read strobe the input register holds its value.
- R8: The capture takes every pin, including pins set up as outputs.
- R9: When a polarity write and a read strobe fall in the same cycle, the capture uses the polarity value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle register write strobe |
| wr_idx | input | 2 | Register index for the write (0 input, 1 output, 2 polarity, 3 direction) |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | One-cycle read strobe that captures the pins |
| rd_idx | input | 2 | Register index shown on rd_data |
| rd_data | output | 8 | Contents of the selected register |
| pin_in | input | 8 | Levels sensed at the pads |
| pin_oe | output | 8 | Per-pin driver enable, 1 = drive |
| pin_out | output | 8 | Per-pin value driven when enabled |

## Verification
A polarity write and an input capture can fall in the same clock cycle. The bench provokes this by raising wr_stb with index 2 and rd_stb together, with the pins held at a known pattern. It then expects the captured byte to equal the pins XORed with the old polarity, and the polarity readback to show the new byte. A second capture then confirms that the new polarity takes effect. A further set of checks reads back the output register while pin_in carries a different pattern, so that the stored value cannot be mistaken for the pin level.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register index encoding for the GPIO register bank.
// Assumes a four-entry register space addressed by a 2-bit index.
package gpio_bank_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds the writable registers (output value, polarity, direction) and
// decodes write strobes. Assumes wr_stb is a single-cycle pulse from the
// bus slave. An index that selects the input register is dropped here.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int              W       = 8,
    parameter logic [W-1:0]    OUT_RST = '0,
    parameter logic [W-1:0]    POL_RST = '0,
    parameter logic [W-1:0]    CFG_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     out_q,
    output logic [W-1:0]     pol_q,
    output logic [W-1:0]     cfg_q
);
    logic hit_out, hit_pol, hit_cfg;

    // Purpose: turn the strobe and index into one write enable per register.
    always_comb begin
        hit_out = 1'b0;
        hit_pol = 1'b0;
        hit_cfg = 1'b0;
        if (wr_stb) begin
            case (reg_sel_e'(wr_idx))
                SEL_OUT: hit_out = 1'b1;
                SEL_POL: hit_pol = 1'b1;
                SEL_CFG: hit_cfg = 1'b1;
                default: ;
            endcase
        end
    end

    // Purpose: output value register.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= OUT_RST;
        else if (hit_out) out_q <= wr_data;
    end

    // Purpose: polarity inversion register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pol_q <= POL_RST;
        else if (hit_pol) pol_q <= wr_data;
    end

    // Purpose: direction register (1 = input).
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= CFG_RST;
        else if (hit_cfg) cfg_q <= wr_data;
    end

    // R1: a reset cycle leaves every writable register at its default
    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (out_q == OUT_RST && pol_q == POL_RST && cfg_q == CFG_RST));

    // R2: an output write lands on the next cycle
    a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SEL_OUT) |=> out_q == $past(wr_data));

    // R2: a polarity write lands on the next cycle
    a_r2_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SEL_POL) |=> pol_q == $past(wr_data));

    // R3: a write aimed at the input register leaves all registers alone
    a_r3_idx0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

// File: rtl/gpio_in_capture.sv
// Module: gpio_in_capture
// Latches pin levels, XORed with the polarity register, on each read strobe.
// Assumes cap_stb marks the acknowledge phase of a byte being read and that
// pin_in is already synchronised to clk.
module gpio_in_capture #(
    parameter int           W      = 8,
    parameter logic [W-1:0] IN_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_stb,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pol,
    output logic [W-1:0] in_q
);
    // Purpose: capture polarity-adjusted pin levels, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_q <= IN_RST;
        else if (cap_stb) in_q <= pin_in ^ pol;
    end

    // R7: without a strobe the captured byte holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(in_q));

    // R7 / R9: a strobe captures the pins with the polarity held in that cycle
    a_r9_capture_old_pol: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> in_q == ($past(pin_in) ^ $past(pol)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: gpio_pad_ctrl
// Derives per-pin driver enable and value from the output and direction
// registers. Bits set in OD_MASK are open-drain: they sink only, never
// source. Purely combinational.
module gpio_pad_ctrl #(
    parameter int           W       = 8,
    parameter logic [W-1:0] OD_MASK = 1
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] cfg_q,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (OD_MASK[i]) begin : g_od
            // Purpose: open-drain pin pulls low only when output bit is 0.
            always_comb begin
                pin_oe[i]  = !cfg_q[i] && !out_q[i];
                pin_out[i] = 1'b0;
            end
        end else begin : g_pp
            // Purpose: push-pull pin drives its stored bit when an output.
            always_comb begin
                pin_oe[i]  = !cfg_q[i];
                pin_out[i] = out_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_polreg_bank.sv
// Module: gpio_polreg_bank (top)
// Register bank of a byte-wide GPIO port: captured input, output value,
// polarity inversion and direction registers, with pad control. Assumes
// write and read strobes come from a bus slave as single-cycle pulses.
module gpio_polreg_bank
    import gpio_bank_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] OUT_RST = 8'h00,
    parameter logic [W-1:0] POL_RST = 8'hF0,
    parameter logic [W-1:0] CFG_RST = 8'hFF,
    parameter logic [W-1:0] IN_RST  = 8'h00,
    parameter logic [W-1:0] OD_MASK = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_stb,
    input  logic [SEL_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     pin_out
);
    logic [W-1:0] out_q, pol_q, cfg_q, in_q;

    gpio_cfg_regs #(
        .W(W), .OUT_RST(OUT_RST), .POL_RST(POL_RST), .CFG_RST(CFG_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
    );

    gpio_in_capture #(.W(W), .IN_RST(IN_RST)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_stb(rd_stb), .pin_in(pin_in),
        .pol(pol_q), .in_q(in_q)
    );

    gpio_pad_ctrl #(.W(W), .OD_MASK(OD_MASK)) u_pad (
        .out_q(out_q), .cfg_q(cfg_q), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // Purpose: present the selected register on the read data bus.
    always_comb begin
        case (reg_sel_e'(rd_idx))
            SEL_IN:  rd_data = in_q;
            SEL_OUT: rd_data = out_q;
            SEL_POL: rd_data = pol_q;
            default: rd_data = cfg_q;
        endcase
    end

    // R1: a reset cycle leaves every pad driver off
    a_r1_no_drive_after_reset: assert property (@(posedge clk)
        !rst_n |=> pin_oe == '0);

    // R4: pins just written as inputs have their drivers off
    a_r4_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SEL_CFG) |=> (pin_oe & $past(wr_data)) == '0);

    // R5: push-pull pins just written as outputs have drivers on
    a_r5_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_idx == SEL_CFG) |=>
            (pin_oe & ~OD_MASK & ~cfg_q) == (~$past(wr_data) & ~OD_MASK & ~cfg_q));

    // R6: open-drain pins never drive high and only pull when output is 0
    a_r6_od_sink_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & OD_MASK & out_q) == '0) && ((pin_out & OD_MASK) == '0));
endmodule

// File: tb/sim_gpio_polreg_bank.sv
// Scoreboard bench: driver tasks push expected items, a monitor on the
// falling edge pops and compares them against the outputs.
module sim_gpio_polreg_bank;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [1:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [1:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    typedef struct {
        int         kind;   // 0 rd_data, 1 pin_oe, 2 pin_out
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   sb_q[$];
    sb_item_t   it;
    logic [7:0] act;

    gpio_polreg_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_idx(rd_idx),
        .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        wr_stb = 1'b1; wr_idx = idx; wr_data = d;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic capture();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic expect_val(input int kind, input logic [1:0] idx,
                              input logic [7:0] exp, input string tag);
        rd_idx = idx;
        sb_q.push_back('{kind: kind, exp: exp, tag: tag});
        tick();
    endtask

    // Monitor: compare the oldest expected item away from the rising edge.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = pin_oe;
                default: act = pin_out;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 defaults
        expect_val(0, 2'd1, 8'h00, "R1 output reset");
        expect_val(0, 2'd2, 8'hF0, "R1 polarity reset");
        expect_val(0, 2'd3, 8'hFF, "R1 direction reset");
        expect_val(0, 2'd0, 8'h00, "R1 input reset");
        expect_val(1, 2'd0, 8'h00, "R1 no driver after reset");

        // R2/R5/R6 all outputs, bit0 written 1
        pin_in = 8'h3C;
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hA5);
        expect_val(0, 2'd1, 8'hA5, "R2 output readback is stored value");
        expect_val(1, 2'd0, 8'hFE, "R6 open-drain high is hi-z, R5 others driven");
        expect_val(2, 2'd0, 8'hA4, "R5 push-pull value, R6 bit0 value 0");

        // R6 bit0 written 0 pulls low
        wr(2'd1, 8'hA4);
        expect_val(1, 2'd0, 8'hFF, "R6 open-drain low enables driver");

        // R4 low nibble back to inputs
        wr(2'd3, 8'h0F);
        expect_val(1, 2'd0, 8'hF0, "R4 input pins not driven");
        expect_val(0, 2'd3, 8'h0F, "R2 direction readback");

        // R3 write to input index ignored
        wr(2'd0, 8'h77);
        expect_val(0, 2'd1, 8'hA4, "R3 output unchanged");
        expect_val(0, 2'd2, 8'hF0, "R3 polarity unchanged");
        expect_val(0, 2'd3, 8'h0F, "R3 direction unchanged");
        expect_val(0, 2'd0, 8'h00, "R3 input unchanged");

        // R7/R8 capture with default polarity, upper nibble are outputs
        pin_in = 8'h3C;
        capture();
        expect_val(0, 2'd0, 8'hCC, "R7 R8 capture pins xor polarity");
        pin_in = 8'h00;
        tick();
        expect_val(0, 2'd0, 8'hCC, "R7 hold without strobe");

        // R7 capture with polarity cleared
        wr(2'd2, 8'h00);
        pin_in = 8'h5A;
        capture();
        expect_val(0, 2'd0, 8'h5A, "R7 capture true levels");

        // R9 polarity write and capture in the same cycle
        pin_in = 8'h0F;
        wr_stb = 1'b1; wr_idx = 2'd2; wr_data = 8'hFF; rd_stb = 1'b1;
        tick();
        wr_stb = 1'b0; rd_stb = 1'b0;
        expect_val(0, 2'd0, 8'h0F, "R9 capture uses old polarity");
        expect_val(0, 2'd2, 8'hFF, "R9 new polarity stored");
        capture();
        expect_val(0, 2'd0, 8'hF0, "R9 next capture uses new polarity");

        // R1 reset again mid-run
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        expect_val(0, 2'd1, 8'h00, "R1 output after second reset");
        expect_val(0, 2'd2, 8'hF0, "R1 polarity after second reset");
        expect_val(1, 2'd0, 8'h00, "R1 drivers off after second reset");

        tick();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule